// File: doc/BRIEF.md
# Pipelined Data Memory Access Controller

This block serves the data-memory side of an in-order five-stage CPU pipeline (Decode, Address, Memory, Execute, Write back). Each word address selects one of two data memories by its top bit. The lower half of the address space maps to a dual-port synchronous RAM. The upper half maps to a single-port synchronous SRAM. A read address presented in the Address stage starts a synchronous read. The data comes back one cycle later, while the instruction occupies the Memory stage.

Writes arrive from the Write-back stage. Dual-port RAM writes go out at once on the second port, so they never collide with a read. SRAM writes enter a small posted-write queue. The queue releases its oldest entry to the SRAM only in a cycle that starts no SRAM read. A read whose address is still in the queue, or is being written in the same cycle, returns the newest pending data. When the queue is full, the block stalls the Write-back stage.

A Memory-stage hold freezes the returned data and blocks the next read in the Address stage. That read is issued once the hold is released.

Top module: `dmem_access_ctrl`

## Requirements
- R1: While `rst` is high, `rd_valid` and `wb_stall` read 0 at the following clock. The posted-write queue is emptied without writing anything to the SRAM, so a queued write lost at reset leaves the earlier SRAM value readable.
- R2: A read accepted in cycle T (`ag_valid` and `ag_ready` high) gives `rd_valid` = 1 and the addressed word on `rd_data` in cycle T+1.
- R3: A dual-port RAM write and a read in the same cycle are both taken with no delay. A read of the address being written in that cycle returns the new data.
- R4: SRAM writes are posted into a queue of `WBUF_DEPTH` (default 2) entries. `wb_stall` is 1 exactly while the queue is full, and an SRAM-region write offered while `wb_stall` is 1 is not taken.
- R5: The queue writes its oldest entry to the SRAM in each cycle that starts no SRAM read. While SRAM reads issue every cycle, the queue does not drain. Entries reach the SRAM in arrival order, so the last write to an address wins.
- R6: A read of an SRAM address held in the queue returns the newest queued data for that address, not the stale SRAM contents.
- R7: While `mem_hold` is 1, `ag_ready` is 0 and no new read is taken, and `rd_valid` and `rd_data` keep their values. The waiting read completes one cycle after `mem_hold` falls.
- R8: Address bit `ADDR_W-1` selects the memory: 0 is the dual-port RAM and 1 is the SRAM. Each memory holds 2^(`ADDR_W-1`) words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ag_valid | input | 1 | Address stage holds a read request |
| ag_addr | input | ADDR_W | Read word address |
| ag_ready | output | 1 | Read can be taken this cycle |
| mem_hold | input | 1 | Pipeline stall holding the Memory stage |
| rd_valid | output | 1 | Memory stage holds returned read data |
| rd_data | output | DATA_W | Returned read data |
| wb_valid | input | 1 | Write-back stage offers a write |
| wb_addr | input | ADDR_W | Write word address |
| wb_data | input | DATA_W | Write data |
| wb_stall | output | 1 | Posted-write queue full; SRAM writes wait |

## Verification
A table of writes to both memories, read back with no other traffic, separates the memory selection from the data path. Paired cycles that write the dual-port RAM while reading it distinguish the same-address and different-address cases. Back-to-back SRAM reads during queued writes show whether draining is suppressed, whether forwarding picks the newest entry, and whether drain order is kept when one address is written twice. A hold with a read waiting, and a reset with the queue full, show that data stays frozen and that discarded writes never reach the SRAM.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic {
    RGN_DUAL = 1'b0,
    RGN_SING = 1'b1
  } rgn_e;

  function automatic rgn_e rgn_of(input logic top_bit);
    return top_bit ? RGN_SING : RGN_DUAL;
  endfunction
endpackage

// File: rtl/dmac_dpram.sv
module dmac_dpram #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_q,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end
endmodule

// File: rtl/dmac_spram.sv
module dmac_spram #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    q <= mem[addr];
    end
  end
endmodule

// File: rtl/dmac_wbuf.sv
module dmac_wbuf #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push,
  input  logic [ADDR_W-1:0]             push_addr,
  input  logic [DATA_W-1:0]             push_data,
  input  logic                          pop,
  output logic                          full,
  output logic                          empty,
  output logic [$clog2(DEPTH+1)-1:0]    occ,
  output logic [ADDR_W-1:0]             head_addr,
  output logic [DATA_W-1:0]             head_data,
  input  logic [ADDR_W-1:0]             look_addr,
  output logic                          hit,
  output logic [DATA_W-1:0]             hit_data
);
  localparam int CW = $clog2(DEPTH+1);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     wr_idx;
  logic [DEPTH-1:0]  match;

  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign occ       = cnt_q;
  assign head_addr = addr_q[0];
  assign head_data = data_q[0];
  assign wr_idx    = cnt_q - CW'(pop);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + CW'(push) - CW'(pop);
  end

  // Entry 0 is always the oldest; a pop shifts every entry down one place.
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i < DEPTH-1) begin : g_mid
      always_ff @(posedge clk) begin
        if (push && wr_idx == CW'(i)) begin
          addr_q[i] <= push_addr;
          data_q[i] <= push_data;
        end else if (pop) begin
          addr_q[i] <= addr_q[i+1];
          data_q[i] <= data_q[i+1];
        end
      end
    end else begin : g_last
      always_ff @(posedge clk) begin
        if (push && wr_idx == CW'(i)) begin
          addr_q[i] <= push_addr;
          data_q[i] <= push_data;
        end
      end
    end
    assign match[i] = (CW'(i) < cnt_q) && (addr_q[i] == look_addr);
  end

  // Newest matching entry wins.
  always_comb begin
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) hit_data = data_q[i];
    end
  end
  assign hit = |match;

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    full |=> !(cnt_q > $past(cnt_q)));
endmodule

// File: rtl/dmem_access_ctrl.sv
module dmem_access_ctrl
  import dmac_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int WBUF_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ag_valid,
  input  logic [ADDR_W-1:0] ag_addr,
  output logic              ag_ready,
  input  logic              mem_hold,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wb_valid,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  output logic              wb_stall
);
  localparam int MEM_AW = ADDR_W - 1;
  localparam int CW     = $clog2(WBUF_DEPTH+1);

  rgn_e              rd_rgn, wr_rgn, sel_q;
  logic              accept, dp_re, sp_re, dp_we, sq_push, sq_pop;
  logic              sq_full, sq_empty, sq_hit;
  logic [CW-1:0]     sq_occ;
  logic [ADDR_W-1:0] sq_head_addr;
  logic [DATA_W-1:0] sq_head_data, sq_hit_data;
  logic              byp_now, fwd_now;
  logic [DATA_W-1:0] fwd_now_data;
  logic              mv_q, fwd_q;
  logic [DATA_W-1:0] fwd_d_q, dp_q, sp_q;
  logic              sp_en;
  logic [MEM_AW-1:0] sp_addr;

  assign rd_rgn   = rgn_of(ag_addr[ADDR_W-1]);
  assign wr_rgn   = rgn_of(wb_addr[ADDR_W-1]);
  assign ag_ready = !mem_hold;
  assign accept   = ag_valid && !mem_hold && !rst;
  assign dp_re    = accept && (rd_rgn == RGN_DUAL);
  assign sp_re    = accept && (rd_rgn == RGN_SING);
  assign dp_we    = wb_valid && !rst && (wr_rgn == RGN_DUAL);
  assign sq_push  = wb_valid && !rst && (wr_rgn == RGN_SING) && !sq_full;
  assign sq_pop   = !sq_empty && !sp_re && !rst;
  assign wb_stall = sq_full;

  // A write taken this cycle is younger than anything queued.
  assign byp_now      = (dp_we || sq_push) && (wb_addr == ag_addr);
  assign fwd_now      = byp_now || (sq_hit && rd_rgn == RGN_SING);
  assign fwd_now_data = byp_now ? wb_data : sq_hit_data;

  assign sp_en   = sp_re || sq_pop;
  assign sp_addr = sp_re ? ag_addr[MEM_AW-1:0] : sq_head_addr[MEM_AW-1:0];

  dmac_dpram #(.ADDR_W(MEM_AW), .DATA_W(DATA_W)) u_dpram (
    .clk     (clk),
    .rd_en   (dp_re),
    .rd_addr (ag_addr[MEM_AW-1:0]),
    .rd_q    (dp_q),
    .wr_en   (dp_we),
    .wr_addr (wb_addr[MEM_AW-1:0]),
    .wr_data (wb_data)
  );

  dmac_spram #(.ADDR_W(MEM_AW), .DATA_W(DATA_W)) u_spram (
    .clk   (clk),
    .en    (sp_en),
    .we    (sq_pop),
    .addr  (sp_addr),
    .wdata (sq_head_data),
    .q     (sp_q)
  );

  dmac_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WBUF_DEPTH)) u_wbuf (
    .clk       (clk),
    .rst       (rst),
    .push      (sq_push),
    .push_addr (wb_addr),
    .push_data (wb_data),
    .pop       (sq_pop),
    .full      (sq_full),
    .empty     (sq_empty),
    .occ       (sq_occ),
    .head_addr (sq_head_addr),
    .head_data (sq_head_data),
    .look_addr (ag_addr),
    .hit       (sq_hit),
    .hit_data  (sq_hit_data)
  );

  always_ff @(posedge clk) begin
    if (rst)           mv_q <= 1'b0;
    else if (!mem_hold) mv_q <= ag_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= RGN_DUAL;
      fwd_q   <= 1'b0;
      fwd_d_q <= '0;
    end else if (accept) begin
      sel_q   <= rd_rgn;
      fwd_q   <= fwd_now;
      fwd_d_q <= fwd_now_data;
    end
  end

  assign rd_valid = mv_q;
  assign rd_data  = fwd_q ? fwd_d_q : (sel_q == RGN_SING ? sp_q : dp_q);

  // R2
  rd_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (ag_valid && ag_ready) |=> rd_valid);

  // R5
  no_drain_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (ag_valid && ag_ready && ag_addr[ADDR_W-1]) |=> (sq_occ >= $past(sq_occ)));

  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_hold && rd_valid) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: tb/tb_dmem_access_ctrl.sv
module tb_dmem_access_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NV = 8;
  localparam logic [AW+DW-1:0] VEC [NV] = '{
    {8'h03, 16'hC3A1}, {8'h80, 16'h8001}, {8'h10, 16'h0F0F}, {8'hFF, 16'h7E57},
    {8'h7F, 16'hFFFF}, {8'h81, 16'h0000}, {8'h40, 16'h1234}, {8'hA5, 16'hA5A5}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ag_valid = 1'b0, mem_hold = 1'b0, wb_valid = 1'b0;
  logic [AW-1:0] ag_addr = '0, wb_addr = '0;
  logic [DW-1:0] wb_data = '0;
  logic          ag_ready, rd_valid, wb_stall;
  logic [DW-1:0] rd_data;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  dmem_access_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WBUF_DEPTH(2)) dut (
    .clk(clk), .rst(rst), .ag_valid(ag_valid), .ag_addr(ag_addr),
    .ag_ready(ag_ready), .mem_hold(mem_hold), .rd_valid(rd_valid),
    .rd_data(rd_data), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .wb_data(wb_data), .wb_stall(wb_stall)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wb_valid = 1'b1; wb_addr = a; wb_data = d;
    #1;
    while (a[AW-1] && wb_stall) @(negedge clk);
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    ag_valid = 1'b1; ag_addr = a;
    @(negedge clk);
    ag_valid = 1'b0;
    chk({tag, " rd_valid"}, {15'd0, rd_valid}, 16'd1);
    chk({tag, " rd_data"}, rd_data, exp);
  endtask

  // Two SRAM writes posted under continuous SRAM reads of rda; returns at the
  // negedge after the second write was taken, reads still running.
  task automatic fill_two(input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                          input logic [AW-1:0] a2, input logic [DW-1:0] d2,
                          input logic [AW-1:0] rda);
    @(negedge clk);
    ag_valid = 1'b1; ag_addr = rda;
    wb_valid = 1'b1; wb_addr = a1; wb_data = d1;
    @(negedge clk);
    wb_addr = a2; wb_data = d2;
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  function automatic logic [DW-1:0] vec_data(input logic [AW-1:0] a);
    for (int i = 0; i < NV; i++)
      if (VEC[i][AW+DW-1:DW] == a) return VEC[i][DW-1:0];
    return '0;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rd_valid in reset", {15'd0, rd_valid}, 16'd0);
    chk("R1 wb_stall in reset", {15'd0, wb_stall}, 16'd0);
    rst = 1'b0;

    // R2/R8: table of writes to both regions, read back
    for (int i = 0; i < NV; i++) do_write(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
    for (int i = 0; i < NV; i++)
      do_read(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0],
              VEC[i][AW+DW-1] ? "R2 R8 sram" : "R2 R8 dpram");

    // R3: same-address write and read in one cycle
    @(negedge clk);
    ag_valid = 1'b1; ag_addr = 8'h10;
    wb_valid = 1'b1; wb_addr = 8'h10; wb_data = 16'hBEEF;
    @(negedge clk);
    ag_valid = 1'b0; wb_valid = 1'b0;
    chk("R3 same-address read", rd_data, 16'hBEEF);
    // R3: write one address while reading another
    @(negedge clk);
    ag_valid = 1'b1; ag_addr = 8'h7F;
    wb_valid = 1'b1; wb_addr = 8'h03; wb_data = 16'h5A5A;
    @(negedge clk);
    ag_valid = 1'b0; wb_valid = 1'b0;
    chk("R3 parallel read", rd_data, vec_data(8'h7F));
    do_read(8'h03, 16'h5A5A, "R3 parallel write");

    // R4/R5/R6: queue fills under SRAM reads
    fill_two(8'h90, 16'hA0A0, 8'h91, 16'hB1B1, 8'h85);
    chk("R4 stall when full", {15'd0, wb_stall}, 16'd1);
    ag_addr = 8'h90;
    @(negedge clk);
    chk("R6 forward entry 0", rd_data, 16'hA0A0);
    chk("R5 no drain while reading", {15'd0, wb_stall}, 16'd1);
    ag_addr = 8'h91;
    @(negedge clk);
    chk("R6 forward entry 1", rd_data, 16'hB1B1);
    ag_valid = 1'b0;
    @(negedge clk);
    chk("R5 drain on idle", {15'd0, wb_stall}, 16'd0);
    do_read(8'h90, 16'hA0A0, "R5 drained word 0");
    do_read(8'h91, 16'hB1B1, "R5 drained word 1");

    // R5/R6: two writes to one address keep their order
    fill_two(8'h92, 16'hC0C0, 8'h92, 16'hD0D0, 8'h85);
    ag_addr = 8'h92;
    @(negedge clk);
    chk("R6 newest entry wins", rd_data, 16'hD0D0);
    ag_valid = 1'b0;
    repeat (3) @(negedge clk);
    do_read(8'h92, 16'hD0D0, "R5 drain order");

    // R7: hold freezes data and delays the waiting read
    @(negedge clk);
    ag_valid = 1'b1; ag_addr = 8'h03;
    @(negedge clk);
    chk("R7 first read", rd_data, 16'h5A5A);
    mem_hold = 1'b1; ag_addr = 8'h40;
    #1;
    chk("R7 ag_ready low", {15'd0, ag_ready}, 16'd0);
    @(negedge clk);
    chk("R7 data frozen", rd_data, 16'h5A5A);
    chk("R7 valid kept", {15'd0, rd_valid}, 16'd1);
    mem_hold = 1'b0;
    @(negedge clk);
    ag_valid = 1'b0;
    chk("R7 delayed read", rd_data, vec_data(8'h40));

    // R1: reset with a full queue discards the queued writes
    do_write(8'h93, 16'hE0E0);
    repeat (2) @(negedge clk);
    fill_two(8'h93, 16'hF1F1, 8'h94, 16'hF2F2, 8'h85);
    rst = 1'b1; ag_valid = 1'b0;
    @(negedge clk);
    chk("R1 rd_valid after reset", {15'd0, rd_valid}, 16'd0);
    chk("R1 wb_stall after reset", {15'd0, wb_stall}, 16'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    do_read(8'h93, 16'hE0E0, "R1 queue discarded");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule